// File: doc/BRIEF.md
# Glitch-Free Gated Clock Fanout

This block takes one free-running source clock and produces a bank of gated copies of it, six by default. Each copy has three conditions that must all hold before it runs. The first is an asynchronous enable pin from the board. The second is an enable bit held in a control register elsewhere on the chip. The third is an output-allow signal from the power sequencer, which applies to every copy at once. If any condition drops, that copy stops and parks low. The other copies keep running untouched.

The enable pin is brought into the source clock domain by a synchronizer chain. All three conditions are then merged into one request flop per output, clocked on the rising edge. A falling-edge flop samples that request, and the copy is the source clock ANDed with it. The gate can therefore only change while the source is low. Every high phase that appears at an output is a complete source high phase. The board holds the pins high and the register bits come out of reset high, so every output runs shortly after reset.

Top module: `gclk_fanout`

## Requirements
- R1: Output i toggles with the source clock only while its pin enable, its register enable bit and the global allow are all 1. Any one of them at 0 keeps the output at 0.
- R2: Global allow at 0 forces every output to 0. Once allow returns to 1, the outputs restart with the register-path latency of R7.
- R3: A disabled output is 0 during both the high and the low phase of the source clock.
- R4: No runt or stretched pulse. An output is 0 whenever the source is 0. Within a source high phase the output is either high for the whole phase or low for the whole phase. The gate changes only while the source is low.
- R5: While reset is asserted, all outputs are 0. With all enables held at 1, the outputs run from the second rising source edge after reset is released.
- R6: Pin path latency is SYNC_STAGES+2 source cycles (4 by default). Take a pin change applied after rising edge j. The first high phase that reflects it begins at rising edge j+4. On a falling pin, the last pulse starts at edge j+3.
- R7: Register-bit and allow latency is 2 source cycles. Take a change applied after rising edge j. The first high phase that reflects it begins at rising edge j+2. On a fall, the last pulse starts at edge j+1.
- R8: Stopping or starting one output leaves the other outputs' pulses unchanged, and every latency falls inside 2 to 6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_en | input | NUM_OUT | Asynchronous per-output enable pins, active high |
| sw_en | input | NUM_OUT | Per-output register enable bits, active high |
| out_allow | input | 1 | Global output allow from the power sequencer, active high |
| clk_out | output | NUM_OUT | Gated clock outputs, parked low when disabled |

## Verification
Every input the bench drives is applied one nanosecond after rising edge j and logged under index j. The bench then predicts the high-phase state of each output at edge k from two entries in that log. The pin values come from index k-4 and the register bit and allow from index k-2, as set out in R6 and R7. Each cycle the outputs are sampled twice inside the high phase, early and late, to confirm the pulse covers the whole phase. They are sampled once more inside the low phase, where every bit must be 0. Directed windows cover pin, register and allow edges on single outputs. Seeded random windows then toggle all three sources freely against the same latency model.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

  // Run condition for one output: all three sources must agree.
  function automatic logic run_cond(input logic pin_ok, input logic sw_bit, input logic allow);
    return pin_ok & sw_bit & allow;
  endfunction

  // Cycles from a pin change (after edge j) to the first edge that reflects it.
  function automatic int unsigned pin_latency(input int unsigned sync_stages);
    return sync_stages + 2;
  endfunction

  // Cycles from a register-bit or allow change to the first edge that reflects it.
  function automatic int unsigned reg_latency();
    return 2;
  endfunction

endpackage

// File: rtl/gclk_sync_bank.sv
module gclk_sync_bank #(
  parameter int unsigned WIDTH   = 6,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL}};
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
    end

    assign sync_o[b] = chain_q[LAST];
  end

endmodule

// File: rtl/gclk_gate_cell.sv
module gclk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ok_i,
  input  logic sw_en_i,
  input  logic allow_i,
  output logic clk_o
);

  logic req_q;   // rising-edge request
  logic gate_q;  // falling-edge gate, changes only in low phase

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= gclk_pkg::run_cond(pin_ok_i, sw_en_i, allow_i);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= req_q;
  end

  assign clk_o = clk_i & gate_q;

  // R4: gate seen at a rising edge equals the request latched one edge earlier
  a_r4_gate_tracks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q == req_q);

  // R1: a low register bit blocks the gate for the next high phase
  a_r1_sw_bit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sw_en_i) |-> !gate_q);

  // R2: a low global allow blocks the gate for the next high phase
  a_r2_allow_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!allow_i) |-> !gate_q);

  // R6: a low synchronized pin keeps the gate closed one edge later
  a_r6_sync_pin_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_ok_i |=> !gate_q);

endmodule

// File: rtl/gclk_fanout.sv
module gclk_fanout #(
  parameter int unsigned NUM_OUT     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] pin_en,
  input  logic [NUM_OUT-1:0] sw_en,
  input  logic               out_allow,
  output logic [NUM_OUT-1:0] clk_out
);

  localparam int unsigned PIN_LAT = gclk_pkg::pin_latency(SYNC_STAGES);
  localparam int unsigned REG_LAT = gclk_pkg::reg_latency();

  // R8: every latency inside the 2..6 cycle window
  initial begin
    a_r8_latency_window: assert (PIN_LAT >= 2 && PIN_LAT <= 6 && REG_LAT >= 2 && SYNC_STAGES >= 2);
  end

  logic [NUM_OUT-1:0] pin_synced;

  gclk_sync_bank #(
    .WIDTH  (NUM_OUT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) i_sync (
    .clk_i  (clk_src),
    .rst_ni (rst_n),
    .async_i(pin_en),
    .sync_o (pin_synced)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    gclk_gate_cell i_cell (
      .clk_i   (clk_src),
      .rst_ni  (rst_n),
      .pin_ok_i(pin_synced[i]),
      .sw_en_i (sw_en[i]),
      .allow_i (out_allow),
      .clk_o   (clk_out[i])
    );
  end

endmodule

// File: tb/test_gclk_fanout.sv
`timescale 1ns/1ps
module test_gclk_fanout;

  localparam int N      = 6;
  localparam int MAXC   = 1200;
  localparam int REL    = 4;   // cycle in which reset is released
  localparam int LAT_P  = 4;   // pin path, R6
  localparam int LAT_R  = 2;   // register / allow path, R7

  logic         clk_src = 1'b0;
  logic         rst_n   = 1'b0;
  logic [N-1:0] pin_en  = '1;
  logic [N-1:0] sw_en   = '1;
  logic         out_allow = 1'b1;
  logic [N-1:0] clk_out;

  logic [N-1:0] pin_h [MAXC];
  logic [N-1:0] sw_h  [MAXC];
  logic         al_h  [MAXC];

  int errors = 0;
  int checks = 0;
  string tag = "R5";

  always #2.5 clk_src = ~clk_src;

  gclk_fanout #(.NUM_OUT(N), .SYNC_STAGES(2)) i_gclk_fanout (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .pin_en   (pin_en),
    .sw_en    (sw_en),
    .out_allow(out_allow),
    .clk_out  (clk_out)
  );

  function automatic logic [N-1:0] expect_high(input int k);
    logic [N-1:0] e;
    if (k < REL + LAT_R) return '0;
    e = sw_h[k-LAT_R] & {N{al_h[k-LAT_R]}};
    e = e & pin_h[k-LAT_P];
    return e;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: clk_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int c);
    pin_en = pin_h[c]; sw_en = sw_h[c]; out_allow = al_h[c];
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    for (int c = 0; c < MAXC; c++) begin
      pin_h[c] = '1; sw_h[c] = '1; al_h[c] = 1'b1;
    end
    // directed windows
    for (int c = 30; c < 45; c++) pin_h[c][2] = 1'b0;       // R6 / R8
    for (int c = 60; c < 63; c++) sw_h[c][4]  = 1'b0;       // R7
    for (int c = 80; c < 81; c++) sw_h[c][0]  = 1'b0;       // R7 one-cycle
    for (int c = 100; c < 110; c++) al_h[c]   = 1'b0;       // R2
    for (int c = 120; c < 122; c++) pin_h[c][5] = 1'b0;     // R6 short
    for (int c = 140; c < 150; c++) begin pin_h[c] = '0; sw_h[c] = '0; end // R3
    // random window, R1
    for (int c = 200; c < MAXC - 20; c++) begin
      pin_h[c] = N'($urandom) | N'($urandom);
      sw_h[c]  = N'($urandom) | N'($urandom);
      al_h[c]  = ($urandom % 8) != 0;
    end

    for (int c = 0; c < MAXC; c++) begin
      @(posedge clk_src);
      #1;
      if (c < REL)        tag = "R5";
      else if (c < 30)    tag = "R5";
      else if (c < 60)    tag = "R6";
      else if (c < 100)   tag = "R7";
      else if (c < 120)   tag = "R2";
      else if (c < 140)   tag = "R8";
      else if (c < 200)   tag = "R3";
      else                tag = "R1";
      check(tag, clk_out, expect_high(c));
      if (c == REL) rst_n = 1'b1;
      drive(c);
      #1.2;
      check("R4", clk_out, expect_high(c));
      @(negedge clk_src);
      #1;
      check("R3", clk_out, '0);
    end
    finish_run();
  end

endmodule